// File: doc/BRIEF.md
# Page Table Address Translator

This block converts a 32-bit virtual address into a physical address by looking up one entry in a flat page table held in memory. Pages are 4 KB. The upper bits of the virtual address select a table entry. The low 12 bits pass through unchanged as the offset inside the page. Software first loads the table base through a small write port. A client then raises a translate request. The block issues a single word read for the entry and waits for the memory to return it. It then strobes either a physical address or a fault, together with the virtual address that was looked up.

Only one translation is in flight at a time. While one is in flight, the block ignores further requests. It also refuses writes to the table base and flags each refused write with a one-cycle error pulse. A translation faults in two cases: the entry is marked invalid, or the physical address it produces lies beyond the configured size of physical memory.

Top module: `vmx_translator`

## Requirements
- R1: After synchronous reset, `xl_busy`, `xl_done`, `mem_rd` and `ptb_err` are low, and the table base is zero, so the first lookup reads address `vpn*4`.
- R2: A request sampled while idle makes `mem_rd` high for exactly one cycle, starting the next cycle. In that cycle `mem_addr` equals base + 4 × `xl_va[31:12]` (modulo 2^32), and `xl_busy` is high.
- R3: `xl_busy` stays high, and `xl_done` stays low, from the cycle after acceptance until the cycle after `mem_rvalid` is sampled. In that cycle `xl_busy` falls and `xl_done` is high for exactly one cycle.
- R4: The entry is a 32-bit word. Bit 31 is the valid flag and bits 19:0 are the frame number. For a valid entry whose result is in range, `xl_fault` is low and `xl_pa` = frame × 4096 + `xl_va[11:0]`.
- R5: For an entry with bit 31 clear, the completion shows `xl_fault` high and `xl_pa` zero. On every completion, `xl_fault_va` equals the request's virtual address.
- R6: A valid entry whose physical address is greater than or equal to `PHYS_SIZE` (default 16 MiB) completes with `xl_fault` high.
- R7: A request raised while busy is ignored: it issues no read, and the completion reports the first request.
- R8: A base write while busy leaves the base unchanged, as later read addresses show, and raises `ptb_err` for one cycle in the following cycle.
- R9: A base write while idle takes effect for later requests and raises no error. A request accepted in the same cycle as the write still uses the previous base.
- R10: Entry bits 30:20 have no effect on the result.
- R11: `mem_rvalid` while idle produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_req | input | 1 | Translate request, sampled when idle |
| xl_va | input | 32 | Virtual address to translate |
| xl_busy | output | 1 | A translation is in flight |
| xl_done | output | 1 | One-cycle completion strobe |
| xl_fault | output | 1 | Completion is a fault (valid with xl_done) |
| xl_pa | output | 32 | Translated physical address |
| xl_fault_va | output | 32 | Virtual address of the completed request |
| ptb_we | input | 1 | Table base write enable |
| ptb_wdata | input | 32 | New table base byte address |
| ptb_err | output | 1 | Pulse: base write refused while busy |
| mem_rd | output | 1 | One-cycle entry read strobe |
| mem_addr | output | 32 | Entry byte address |
| mem_rvalid | input | 1 | Entry data returned |
| mem_rdata | input | 32 | Entry word |

## Verification
The bench sweeps many page numbers, offsets and memory latencies of zero to three cycles. It then targets the corner cases. One is the range limit, probed just under and just over `PHYS_SIZE`. A wrong comparison or off-by-one would pass a frame that should fault, or would fault the last legal byte. Another is the pair of collisions with a busy walk. A stray request would issue a second read. A base write that leaks through would move the next lookup's address. The last group covers a base write that arrives in the same cycle as a request, a stray `mem_rvalid` while idle, and junk in the reserved entry bits. Each of these would show up as a wrong `mem_addr`, a spurious strobe, or a changed result.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  parameter int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
  typedef struct packed {
    logic  fault;
    word_t pa;
  } xl_res_t;
endpackage

// File: rtl/vmx_ptb_reg.sv
module vmx_ptb_reg
  import vmx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t wdata,
  input  logic  busy,
  output word_t base,
  output logic  err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      err  <= 1'b0;
    end else begin
      err <= 1'b0;
      if (we) begin
        if (busy) err  <= 1'b1;
        else      base <= wdata;
      end
    end
  end

  // R8
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (we && busy) |=> ($stable(base) && err));
  // R9
  base_load_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !busy) |=> (base == $past(wdata) && !err));
endmodule

// File: rtl/vmx_entry_check.sv
module vmx_entry_check
  import vmx_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int VALID_BIT = 31,
  parameter logic [WORD_W:0] PHYS_SIZE = 33'h0_0100_0000
) (
  input  word_t   entry,
  input  word_t   va,
  output xl_res_t res
);
  localparam int PA_W = PFN_W + PAGE_BITS;
  localparam logic [WORD_W:0] PA_SPAN = (WORD_W+1)'(1) << PA_W;

  word_t pa;
  logic  over;
  logic  vld;

  assign vld = entry[VALID_BIT];
  assign pa  = word_t'({entry[PFN_W-1:0], va[PAGE_BITS-1:0]});

  generate
    if (PHYS_SIZE >= PA_SPAN) begin : g_nolimit
      assign over = 1'b0;
    end else begin : g_limit
      assign over = ({1'b0, pa} >= PHYS_SIZE);
    end
  endgenerate

  assign res.fault = !vld || over;
  assign res.pa    = pa;
endmodule

// File: rtl/vmx_walk.sv
module vmx_walk
  import vmx_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  word_t   va,
  input  word_t   base,
  input  logic    rvalid,
  input  xl_res_t res,
  output logic    busy,
  output logic    rd,
  output word_t   addr,
  output word_t   va_q,
  output logic    done,
  output logic    fault,
  output word_t   pa,
  output word_t   fault_va
);
  localparam int VPN_W = WORD_W - PAGE_BITS;

  logic [VPN_W-1:0] vpn;
  assign vpn = va[WORD_W-1:PAGE_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rd       <= 1'b0;
      done     <= 1'b0;
      fault    <= 1'b0;
      addr     <= '0;
      va_q     <= '0;
      pa       <= '0;
      fault_va <= '0;
    end else begin
      rd   <= 1'b0;
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy <= 1'b1;
          rd   <= 1'b1;
          va_q <= va;
          addr <= base + word_t'({vpn, 2'b00});
        end
      end else if (rvalid) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        fault    <= res.fault;
        pa       <= res.fault ? '0 : res.pa;
        fault_va <= va_q;
      end
    end
  end

  // R2
  rd_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> (rd && busy));
  // R3
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R7
  ignored_req_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rd);
  // R11
  idle_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !done);
  // R4
  offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (pa[PAGE_BITS-1:0] == fault_va[PAGE_BITS-1:0]));
endmodule

// File: rtl/vmx_translator.sv
module vmx_translator
  import vmx_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int VALID_BIT = 31,
  parameter logic [WORD_W:0] PHYS_SIZE = 33'h0_0100_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        xl_req,
  input  logic [31:0] xl_va,
  output logic        xl_busy,
  output logic        xl_done,
  output logic        xl_fault,
  output logic [31:0] xl_pa,
  output logic [31:0] xl_fault_va,
  input  logic        ptb_we,
  input  logic [31:0] ptb_wdata,
  output logic        ptb_err,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  word_t   base;
  word_t   va_q;
  xl_res_t res;

  vmx_ptb_reg u_ptb (
    .clk(clk), .rst(rst), .we(ptb_we), .wdata(ptb_wdata),
    .busy(xl_busy), .base(base), .err(ptb_err)
  );

  vmx_entry_check #(
    .PAGE_BITS(PAGE_BITS), .PFN_W(PFN_W),
    .VALID_BIT(VALID_BIT), .PHYS_SIZE(PHYS_SIZE)
  ) u_chk (
    .entry(mem_rdata), .va(va_q), .res(res)
  );

  vmx_walk #(.PAGE_BITS(PAGE_BITS)) u_walk (
    .clk(clk), .rst(rst), .req(xl_req), .va(xl_va), .base(base),
    .rvalid(mem_rvalid), .res(res), .busy(xl_busy), .rd(mem_rd),
    .addr(mem_addr), .va_q(va_q), .done(xl_done), .fault(xl_fault),
    .pa(xl_pa), .fault_va(xl_fault_va)
  );
endmodule

// File: tb/tb_vmx_translator.sv
module tb_vmx_translator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xl_req = 1'b0;
  logic [31:0] xl_va = '0;
  logic        xl_busy, xl_done, xl_fault, ptb_err, mem_rd;
  logic [31:0] xl_pa, xl_fault_va, mem_addr;
  logic        ptb_we = 1'b0;
  logic [31:0] ptb_wdata = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] cur_base = '0;
  localparam logic [32:0] LIM = 33'h0_0100_0000;

  always #4 clk = ~clk;

  vmx_translator dut (
    .clk(clk), .rst(rst), .xl_req(xl_req), .xl_va(xl_va),
    .xl_busy(xl_busy), .xl_done(xl_done), .xl_fault(xl_fault),
    .xl_pa(xl_pa), .xl_fault_va(xl_fault_va), .ptb_we(ptb_we),
    .ptb_wdata(ptb_wdata), .ptb_err(ptb_err), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one full translation; optional collisions during the wait
  task automatic xlate(input logic [31:0] va, input logic [31:0] ent, input int lat,
                       input bit poke_req, input bit poke_base,
                       input bit wr_now, input logic [31:0] wd, input string tag);
    logic [31:0] pa_e;
    logic        flt_e;
    @(negedge clk);
    xl_req = 1'b1; xl_va = va;
    if (wr_now) begin ptb_we = 1'b1; ptb_wdata = wd; end
    @(negedge clk);
    xl_req = 1'b0; ptb_we = 1'b0;
    chk("R2 read strobe", {31'd0, mem_rd}, 32'd1);
    chk("R2 busy", {31'd0, xl_busy}, 32'd1);
    chk(wr_now ? "R9 same-cycle old base" : "R2 addr", mem_addr, cur_base + {10'd0, va[31:12], 2'b00});
    if (wr_now) cur_base = wd;
    for (int i = 0; i < lat; i++) begin
      if (i == 0 && poke_req) begin xl_req = 1'b1; xl_va = ~va; end
      if (i == 0 && poke_base) begin ptb_we = 1'b1; ptb_wdata = 32'hDEAD_0000; end
      @(negedge clk);
      xl_req = 1'b0; ptb_we = 1'b0;
      chk("R7 no extra read", {31'd0, mem_rd}, 32'd0);
      chk("R3 busy held", {30'd0, xl_busy, xl_done}, 32'd2);
      if (i == 0 && poke_base) chk("R8 err pulse", {31'd0, ptb_err}, 32'd1);
      if (i == 1 && poke_base) chk("R8 err one cycle", {31'd0, ptb_err}, 32'd0);
    end
    mem_rvalid = 1'b1; mem_rdata = ent;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = 32'h5A5A_5A5A;
    pa_e  = {ent[19:0], va[11:0]};
    flt_e = !ent[31] || ({1'b0, pa_e} >= LIM);
    chk("R3 done/busy at completion", {30'd0, xl_busy, xl_done}, 32'd1);
    chk({tag, " fault"}, {31'd0, xl_fault}, {31'd0, flt_e});
    chk({tag, " pa"}, xl_pa, flt_e ? 32'd0 : pa_e);
    chk("R5 fault_va", xl_fault_va, va);
    @(negedge clk);
    chk("R3 done one cycle", {31'd0, xl_done}, 32'd0);
  endtask

  task automatic wbase(input logic [31:0] v);
    @(negedge clk);
    ptb_we = 1'b1; ptb_wdata = v;
    @(negedge clk);
    ptb_we = 1'b0;
    cur_base = v;
    chk("R9 no err when idle", {31'd0, ptb_err}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset outputs", {28'd0, xl_busy, xl_done, mem_rd, ptb_err}, 32'd0);
    // R1: zero base on first lookup
    xlate(32'h0003_4567, 32'h8000_0042, 1, 0, 0, 0, 0, "R4");

    wbase(32'h0004_0000);
    // sweep page numbers, offsets and latencies (R2, R4)
    for (int vi = 0; vi < 32; vi++) begin
      for (int k = 0; k < 3; k++) begin
        logic [11:0] off;
        logic [19:0] vpn;
        logic [19:0] pfn;
        off = (k == 0) ? 12'h000 : (k == 1) ? 12'h123 : 12'hFFF;
        vpn = 20'(vi * 32'h8421);
        pfn = 20'((vi * 37 + k * 5) & 32'hFFF);
        xlate({vpn, off}, {1'b1, 11'd0, pfn}, vi % 4, 0, 0, 0, 0, "R4 sweep");
      end
    end
    // R6: range limit boundaries
    xlate(32'h1234_5FFF, 32'h8000_0FFF, 1, 0, 0, 0, 0, "R6 last legal");
    xlate(32'h1234_5000, 32'h8000_1000, 1, 0, 0, 0, 0, "R6 first over");
    xlate(32'hFFFF_FABC, 32'h800F_FFFF, 2, 0, 0, 0, 0, "R6 top frame");
    for (int vi = 0; vi < 8; vi++)
      xlate({20'(vi), 12'h010}, {1'b1, 11'd0, 20'(32'h1000 + vi * 97)}, 0, 0, 0, 0, 0, "R6 sweep");
    // R5: invalid entries
    xlate(32'h0000_1ABC, 32'h0000_0012, 1, 0, 0, 0, 0, "R5 invalid");
    xlate(32'h7777_7001, 32'h7FFF_FFFF, 3, 0, 0, 0, 0, "R5 invalid junk");
    // R10: reserved bits set
    xlate(32'h0005_5321, 32'hFFF0_0ABC, 1, 0, 0, 0, 0, "R10 reserved");
    // R7: request while busy
    xlate(32'h0009_9888, 32'h8000_0333, 2, 1, 0, 0, 0, "R7 first kept");
    // R8: base write while busy, then base unchanged
    xlate(32'h000A_A000, 32'h8000_0111, 2, 0, 1, 0, 0, "R8 result");
    xlate(32'h000B_B000, 32'h8000_0222, 1, 0, 0, 0, 0, "R8 base kept");
    // R9: write with request in same cycle, then new base used
    xlate(32'h000C_C000, 32'h8000_0444, 1, 0, 0, 1, 32'h0010_0000, "R9 same cycle");
    xlate(32'h000D_D000, 32'h8000_0555, 1, 0, 0, 0, 0, "R9 new base");
    // R11: stray rvalid while idle
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'h8000_0001;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R11 no done", {30'd0, xl_busy, xl_done}, 32'd0);
    @(negedge clk);
    chk("R11 still idle", {30'd0, xl_busy, xl_done}, 32'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule